// File: doc/BRIEF.md
# Age-Gated Hint Release Buffer

This block sits between a run-ahead producer core and a consumer core that executes the same program. The producer writes hint records into one shared queue as its instructions commit. Each record has four fields: a type, an age tag, a PC and a second value. The block holds every record until the consumer has committed enough instructions to reach it. It then sends the record to the consumer port that matches its type: instruction prefetch, data prefetch or branch-predictor update.

The queue releases its head only when the head's age tag is at most the consumer's committed-instruction count plus a lookahead window. That window is a plain input and is sampled every cycle. The block discards a head record without delivering it in two cases: its type code is reserved, or its age has fallen more than a programmable stale limit behind the committed count. The producer side has no ready signal and is never stalled. A record that arrives when the queue is full is lost and counted. A flush request, raised when the two cores resynchronise, empties the queue in one cycle.

Each output port follows valid/ready rules. A port raises valid only while the head record is released and is of that port's type. The record and its data stay fixed until the port's ready is sampled high at a clock edge. Until then every later record waits behind it, including records for other ports that are ready. Control inputs and the drop counter are plain signals.

Top module: `hint_release_buffer`

## Requirements
- R1: While reset is asserted and directly after it is released, all three port valids are low and the drop counter reads 0.
- R2: All record types share one first-in first-out queue, and records are delivered in the order they were pushed.
- R3: The head is offered only when its age is less than or equal to commit_count + window. This sum is computed unsigned, one bit wider than the operands, so it never wraps.
- R4: Type code 0 goes to the instruction port, which carries the PC. Code 1 goes to the data port, which carries the value field as the address. Code 2 goes to the branch port, which carries both the PC and the value field as the next-PC. At most one port valid is high at a time.
- R5: The head advances only when the port that is offering it has ready high at a clock edge. Until then that port's valid and data stay fixed, and later records are blocked.
- R6: A head record with type code 3 is removed without appearing on any port.
- R7: If a record arrives while the queue is full and no flush is requested, the record is dropped and the drop counter increments. The counter saturates at its maximum value.
- R8: A flush empties the queue by the next cycle. A record pushed in the same cycle as a flush is neither stored nor counted as dropped.
- R9: If commit_count > stale_limit and age < commit_count − stale_limit, the head record is removed without being delivered. A record whose age equals commit_count − stale_limit is still delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Producer record strobe |
| in_kind | input | 2 | Record type code |
| in_age | input | AGE_W | Age tag of the record |
| in_pc | input | PC_W | PC field |
| in_val | input | PC_W | Address or next-PC field |
| commit_count | input | AGE_W | Consumer committed-instruction count |
| window | input | AGE_W | Lookahead window |
| stale_limit | input | AGE_W | Age distance beyond which the head is discarded |
| flush | input | 1 | Empties the queue |
| ic_valid | output | 1 | Instruction-prefetch hint valid |
| ic_ready | input | 1 | Instruction-prefetch port ready |
| ic_pc | output | PC_W | Instruction-prefetch PC |
| dc_valid | output | 1 | Data-prefetch hint valid |
| dc_ready | input | 1 | Data-prefetch port ready |
| dc_addr | output | PC_W | Data-prefetch address |
| bp_valid | output | 1 | Branch-update hint valid |
| bp_ready | input | 1 | Branch-update port ready |
| bp_pc | output | PC_W | Branch PC |
| bp_npc | output | PC_W | Branch next-PC |
| drop_count | output | DROP_W | Saturating count of records dropped because the queue was full |

## Verification
The bench tests the release gate at the exact equality point. It also tests it with a count and window whose sum passes the top of the age range: a design that wrapped the sum would hold that record forever. It stalls one port and checks that a later record for a ready port does not overtake the stalled one, which a design that routed each type independently would let happen. It pushes into a full queue together with a flush and checks that the counter ignores that record. It also drives the counter to saturation, where a wrapping counter would return to zero. The stale boundary is tested one step on each side, so a design with an off-by-one comparison either drops a record that is still useful or delivers one that is too old.

// File: rtl/hint_pkg.sv
package hint_pkg;
  localparam int KIND_W = 2;

  typedef enum logic [KIND_W-1:0] {
    HK_IFETCH = 2'd0,
    HK_DATA   = 2'd1,
    HK_BRANCH = 2'd2,
    HK_RSVD   = 2'd3
  } hint_kind_e;
endpackage

// File: rtl/hint_fifo.sv
module hint_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  input  logic         flush,
  output logic         full,
  output logic         empty,
  output logic [W-1:0] dout
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= din;
  end

  assert_no_pop_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/hint_release_gate.sv
module hint_release_gate #(
  parameter int AGE_W = 16
) (
  input  logic [AGE_W-1:0] age,
  input  logic [AGE_W-1:0] commit_count,
  input  logic [AGE_W-1:0] window,
  input  logic [AGE_W-1:0] stale_limit,
  output logic             eligible,
  output logic             stale
);
  logic [AGE_W:0]   reach;
  logic [AGE_W-1:0] floor_age;

  always_comb begin
    reach     = {1'b0, commit_count} + {1'b0, window};
    eligible  = ({1'b0, age} <= reach);
    floor_age = commit_count - stale_limit;
    stale     = (commit_count > stale_limit) && (age < floor_age);
  end
endmodule

// File: rtl/hint_route.sv
module hint_route
  import hint_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            present,
  input  hint_kind_e      kind,
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] val,
  input  logic            ic_ready,
  input  logic            dc_ready,
  input  logic            bp_ready,
  output logic            ic_valid,
  output logic            dc_valid,
  output logic            bp_valid,
  output logic [PC_W-1:0] ic_pc,
  output logic [PC_W-1:0] dc_addr,
  output logic [PC_W-1:0] bp_pc,
  output logic [PC_W-1:0] bp_npc,
  output logic            accept
);
  always_comb begin
    ic_valid = present && (kind == HK_IFETCH);
    dc_valid = present && (kind == HK_DATA);
    bp_valid = present && (kind == HK_BRANCH);
    ic_pc    = pc;
    dc_addr  = val;
    bp_pc    = pc;
    bp_npc   = val;
    accept   = (ic_valid && ic_ready) || (dc_valid && dc_ready) ||
               (bp_valid && bp_ready);
  end

  assert_one_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ic_valid, dc_valid, bp_valid}));
endmodule

// File: rtl/hint_release_buffer.sv
module hint_release_buffer
  import hint_pkg::*;
#(
  parameter int AGE_W  = 16,
  parameter int PC_W   = 32,
  parameter int DEPTH  = 8,
  parameter int DROP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [KIND_W-1:0] in_kind,
  input  logic [AGE_W-1:0]  in_age,
  input  logic [PC_W-1:0]   in_pc,
  input  logic [PC_W-1:0]   in_val,
  input  logic [AGE_W-1:0]  commit_count,
  input  logic [AGE_W-1:0]  window,
  input  logic [AGE_W-1:0]  stale_limit,
  input  logic              flush,
  output logic              ic_valid,
  input  logic              ic_ready,
  output logic [PC_W-1:0]   ic_pc,
  output logic              dc_valid,
  input  logic              dc_ready,
  output logic [PC_W-1:0]   dc_addr,
  output logic              bp_valid,
  input  logic              bp_ready,
  output logic [PC_W-1:0]   bp_pc,
  output logic [PC_W-1:0]   bp_npc,
  output logic [DROP_W-1:0] drop_count
);
  localparam int REC_W = KIND_W + AGE_W + 2 * PC_W;

  logic [REC_W-1:0]  in_rec, head_rec;
  logic              q_full, q_empty, q_push, q_pop;
  hint_kind_e        head_kind;
  logic [AGE_W-1:0]  head_age;
  logic [PC_W-1:0]   head_pc, head_val;
  logic              eligible, stale, present, discard, accept, drop_evt;

  assign in_rec = {in_kind, in_age, in_pc, in_val};
  assign {head_kind, head_age, head_pc, head_val} = head_rec;

  assign q_push   = in_valid && !flush;
  assign drop_evt = in_valid && q_full && !flush;
  assign discard  = !q_empty && (stale || head_kind == HK_RSVD);
  assign present  = !q_empty && !stale && eligible && head_kind != HK_RSVD;
  assign q_pop    = discard || (present && accept);

  hint_fifo #(.W(REC_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(q_push), .din(in_rec), .pop(q_pop),
    .flush(flush), .full(q_full), .empty(q_empty), .dout(head_rec)
  );

  hint_release_gate #(.AGE_W(AGE_W)) u_gate (
    .age(head_age), .commit_count(commit_count), .window(window),
    .stale_limit(stale_limit), .eligible(eligible), .stale(stale)
  );

  hint_route #(.PC_W(PC_W)) u_route (
    .clk(clk), .rst_n(rst_n), .present(present), .kind(head_kind),
    .pc(head_pc), .val(head_val), .ic_ready(ic_ready), .dc_ready(dc_ready),
    .bp_ready(bp_ready), .ic_valid(ic_valid), .dc_valid(dc_valid),
    .bp_valid(bp_valid), .ic_pc(ic_pc), .dc_addr(dc_addr), .bp_pc(bp_pc),
    .bp_npc(bp_npc), .accept(accept)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                        drop_count <= '0;
    else if (drop_evt && !(&drop_count)) drop_count <= drop_count + 1'b1;
  end

  assert_drop_monotonic_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> drop_count >= $past(drop_count));
  assert_drop_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && q_full && !flush && !(&drop_count)) |=>
      drop_count == $past(drop_count) + 1'b1);
endmodule

// File: tb/hint_release_buffer_bench.sv
`timescale 1ns/1ps
module hint_release_buffer_bench;
  localparam int AGE_W = 16, PC_W = 32, DEPTH = 8, DROP_W = 8;

  typedef struct packed {
    logic [1:0]      k;
    logic [PC_W-1:0] a;
    logic [PC_W-1:0] b;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, flush = 0;
  logic [1:0] in_kind = 0;
  logic [AGE_W-1:0] in_age = 0, commit_count = 0, window = 0, stale_limit = '1;
  logic [PC_W-1:0] in_pc = 0, in_val = 0;
  logic ic_ready = 0, dc_ready = 0, bp_ready = 0;
  logic ic_valid, dc_valid, bp_valid;
  logic [PC_W-1:0] ic_pc, dc_addr, bp_pc, bp_npc;
  logic [DROP_W-1:0] drop_count;

  int total = 0, bad = 0;
  bit done = 0;
  exp_t sb[$];

  always #2 clk = ~clk;

  hint_release_buffer #(.AGE_W(AGE_W), .PC_W(PC_W), .DEPTH(DEPTH), .DROP_W(DROP_W))
  u_hint_release_buffer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
    .in_age(in_age), .in_pc(in_pc), .in_val(in_val),
    .commit_count(commit_count), .window(window), .stale_limit(stale_limit),
    .flush(flush), .ic_valid(ic_valid), .ic_ready(ic_ready), .ic_pc(ic_pc),
    .dc_valid(dc_valid), .dc_ready(dc_ready), .dc_addr(dc_addr),
    .bp_valid(bp_valid), .bp_ready(bp_ready), .bp_pc(bp_pc), .bp_npc(bp_npc),
    .drop_count(drop_count)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic push(input logic [1:0] k, input logic [AGE_W-1:0] age,
                      input logic [PC_W-1:0] pc, input logic [PC_W-1:0] v, input bit expect_out);
    @(negedge clk);
    in_valid = 1; in_kind = k; in_age = age; in_pc = pc; in_val = v;
    if (expect_out) sb.push_back('{k: k, a: (k == 2'd1) ? v : pc, b: v});
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic drain(input string tag);
    repeat (20) settle();
    check(sb.size() == 0, tag, sb.size(), 0);
  endtask

  task automatic no_valid(input string tag);
    check(!(ic_valid || dc_valid || bp_valid), tag, {ic_valid, dc_valid, bp_valid}, 0);
  endtask

  // Scoreboard monitor: every handshake must match the oldest expected record (R2, R4)
  always @(negedge clk) begin
    #1;
    if (rst_n && (ic_valid || dc_valid || bp_valid)) begin
      check($countones({ic_valid, dc_valid, bp_valid}) == 1, "R4 one port",
            {ic_valid, dc_valid, bp_valid}, 0);
      if ((ic_valid && ic_ready) || (dc_valid && dc_ready) || (bp_valid && bp_ready)) begin
        if (sb.size() == 0) begin
          check(0, "R2 unexpected delivery", ic_valid ? ic_pc : (dc_valid ? dc_addr : bp_pc), 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (ic_valid) check(e.k == 2'd0 && ic_pc == e.a, "R2 R4 instr port", ic_pc, e.a);
          if (dc_valid) check(e.k == 2'd1 && dc_addr == e.a, "R2 R4 data port", dc_addr, e.a);
          if (bp_valid) check(e.k == 2'd2 && bp_pc == e.a && bp_npc == e.b,
                              "R2 R4 branch port", {bp_pc, bp_npc}, {e.a, e.b});
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset
    repeat (2) settle();
    no_valid("R1 valids in reset");
    @(negedge clk); rst_n = 1;
    settle();
    no_valid("R1 valids after reset");
    check(drop_count == 0, "R1 drop count", drop_count, 0);

    // R2 R4 order and routing
    commit_count = 100; window = 10; stale_limit = '1;
    ic_ready = 1; dc_ready = 1; bp_ready = 1;
    push(2'd0, 50, 32'h1000, 32'h0, 1);
    push(2'd1, 60, 32'h2000, 32'hA000, 1);
    push(2'd2, 70, 32'h3000, 32'h3040, 1);
    push(2'd1, 80, 32'h2100, 32'hA100, 1);
    drain("R2 all delivered");

    // R3 release gate
    push(2'd2, 111, 32'h4000, 32'h4010, 0);
    repeat (5) settle();
    no_valid("R3 held above window");
    @(negedge clk); commit_count = 101;
    sb.push_back('{k: 2'd2, a: 32'h4000, b: 32'h4010});
    drain("R3 released at equality");
    commit_count = 16'hFFF0; window = 16'h0020;
    push(2'd0, 16'hFFFF, 32'h4400, 32'h0, 1);
    drain("R3 no wrap of count plus window");

    // R5 back-pressure and head blocking
    commit_count = 100; window = 10;
    ic_ready = 0; dc_ready = 1;
    push(2'd0, 90, 32'h5000, 32'h0, 1);
    push(2'd1, 91, 32'h5100, 32'hB100, 1);
    repeat (3) begin
      settle();
      check(ic_valid && ic_pc == 32'h5000, "R5 held offer", ic_pc, 32'h5000);
      check(!dc_valid, "R5 later record blocked", dc_valid, 0);
    end
    @(negedge clk); ic_ready = 1;
    drain("R5 drained after ready");

    // R6 reserved type discarded
    push(2'd3, 95, 32'h6000, 32'h6000, 0);
    push(2'd0, 96, 32'h6100, 32'h0, 1);
    drain("R6 reserved skipped");

    // R9 stale boundary
    commit_count = 1000; stale_limit = 100; window = 10;
    push(2'd1, 899, 32'h7000, 32'hC000, 0);
    push(2'd1, 900, 32'h7100, 32'hC100, 1);
    drain("R9 stale dropped, boundary kept");
    stale_limit = '1;

    // R8 flush on a full queue with simultaneous push
    ic_ready = 0; dc_ready = 0; bp_ready = 0;
    for (int i = 0; i < DEPTH; i++) push(2'd0, 900, 32'h8000 + i, 32'h0, 0);
    @(negedge clk);
    flush = 1; in_valid = 1; in_kind = 2'd0; in_age = 900; in_pc = 32'h8F00;
    @(negedge clk);
    flush = 0; in_valid = 0;
    #1;
    no_valid("R8 empty after flush");
    check(drop_count == 0, "R8 flush-cycle push not counted", drop_count, 0);
    ic_ready = 1; dc_ready = 1; bp_ready = 1;
    repeat (4) settle();
    no_valid("R8 nothing left");
    push(2'd2, 900, 32'h8800, 32'h8804, 1);
    drain("R8 queue usable after flush");

    // R7 overflow drop and saturation
    ic_ready = 0; dc_ready = 0; bp_ready = 0;
    for (int i = 0; i < DEPTH; i++) push(2'd1, 900, 32'h9000, 32'hD000 + i, 1);
    for (int i = 0; i < 3; i++) push(2'd1, 900, 32'h9F00, 32'hDF00 + i, 0);
    settle();
    check(drop_count == 3, "R7 drop count", drop_count, 3);
    for (int i = 0; i < 260; i++) push(2'd0, 900, 32'h9E00, 32'h0, 0);
    settle();
    check(drop_count == 8'hFF, "R7 drop saturates", drop_count, 8'hFF);
    ic_ready = 1; dc_ready = 1; bp_ready = 1;
    drain("R7 stored records intact");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule